// File: doc/BRIEF.md
# Modem Handshake Status and Control

This block is the modem-handshake slice of a serial port's register file. It brings four active-low handshake inputs (clear-to-send, data-set-ready, ring and carrier) into the clock domain through two-flop synchronizers. It keeps a current-level bit and a sticky change flag for each input in a status register, and it raises a modem-status interrupt request from those flags.

A control register drives the active-low terminal-ready and request-to-send outputs, a general-purpose output and the enable of the interrupt pin. A loopback bit disconnects the handshake pins and feeds control bits back into the status register, so software can test the path without a modem.

The host uses a single-cycle read strobe and a single-cycle write strobe with a 3-bit address. The control register sits at address 4 and the status register at address 6. A status read returns the flags and clears them in the same access.

Top module: `modem_ctl_status`

## Requirements
- R1: Status bits 7, 6, 5 and 4 show carrier, ring, data-set-ready and clear-to-send. A bit reads 1 while its pin is low. A pin change that is stable before clock edge k is visible after edge k+1.
- R2: Status bits 0, 1 and 3 are sticky flags. Each sets one edge after the level bit of clear-to-send, data-set-ready or carrier changes in either direction.
- R3: Status bit 2 sets only when the ring level bit goes from 1 to 0, which is the ring pin rising from low to high. The opposite edge leaves it clear.
- R4: A read at address 6 returns the flags before they are cleared, and bits 0 to 3 clear at that edge. A change that falls in the read cycle itself sets its flag again, so the next read reports it.
- R5: `msi_req` is high when `msi_en` is high and at least one of these holds: the flag for data-set-ready, ring or carrier is set, or the clear-to-send flag is set while `auto_cts_en` is low.
- R6: `dtr_n` is low exactly when control bit 0 is 1 and loopback (control bit 4) is 0.
- R7: `rts_n` is low exactly when all three hold: control bit 1 is 1, loopback is 0, and `auto_rts_en` and `rx_thresh_hit` are not both high.
- R8: Control bit 3 at 1 drives `aux_out_n` to 0 and `irq_oe` to 1. At 0, it drives `aux_out_n` to 1 and `irq_oe` to 0.
- R9: With loopback on, the level bits come from control bits: bit 1 for clear-to-send, bit 0 for data-set-ready, bit 2 for ring and bit 3 for carrier. Pin activity has no effect in this mode.
- R10: A read at address 4 returns control bits 4:0, with bits 7:5 reading 0. Writes to any address other than 4 leave the control register unchanged. Reads at other addresses, and cycles with no read, return 0.
- R11: A synchronous active-low reset clears the control register and all flags. After reset `dtr_n`, `rts_n` and `aux_out_n` are 1, and `irq_oe` and `msi_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is active |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| cd_n | input | 1 | Carrier pin, active low |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_cts_en | input | 1 | Automatic clear-to-send flow control on |
| auto_rts_en | input | 1 | Automatic request-to-send flow control on |
| rx_thresh_hit | input | 1 | Receiver threshold reached |
| dtr_n | output | 1 | Terminal-ready output, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| aux_out_n | output | 1 | General-purpose output, inverse of control bit 3 |
| irq_oe | output | 1 | Interrupt pin drive enable |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The case that needs care is a status read landing on the same edge as a new change flag, because the clear and the set then compete for one bit. The bench toggles a pin and then issues a read one, two, three or four cycles later, so the read falls before, on and after the edge where the flag sets. At every clock a behavioural model predicts the read data and the interrupt request, and the next read must show exactly the flags the model kept. Loopback writes are also timed against reads, which puts the same race on the control-driven path.

// File: rtl/mdm_pkg.sv
// Package: shared constants and the control-register layout for the modem
// handshake block. Assumes an 8-bit host data bus.
package mdm_pkg;
    localparam int NUM_LINES = 4;
    localparam int LN_CTS    = 0;
    localparam int LN_DSR    = 1;
    localparam int LN_RI     = 2;
    localparam int LN_CD     = 3;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 3'd6;

    // Control register, packed so that dtr sits at bit 0 and loop at bit 4
    typedef struct packed {
        logic loop;
        logic out_en;
        logic ri_lb;
        logic rts;
        logic dtr;
    } ctrl_t;
    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous active-low
// pins. Every stage resets to all ones, the idle level of the pins, so leaving
// reset creates no false change. Assumes each bit is synchronized on its own.
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '1;
        else        stg[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Later stages shift the sample along
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= '1;
            else        stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
// Module: change detection and sticky flags for the four handshake levels.
// The input is the effective active-high level of each line, from pins or
// from loopback. Assumes line order CTS, DSR, RI, CD at indices 0..3.
module mdm_status
    import mdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_clr,
    input  logic [NUM_LINES-1:0] lvl,
    output logic [NUM_LINES-1:0] flags
);
    logic [NUM_LINES-1:0] prev;
    logic [NUM_LINES-1:0] chg;
    logic [NUM_LINES-1:0] set_now;

    // Work out which flags this cycle's levels raise
    always_comb begin
        chg              = lvl ^ prev;
        set_now          = chg;
        set_now[LN_RI]   = prev[LN_RI] & ~lvl[LN_RI];
    end

    // Remember the last level seen on each line
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    // Sticky flags: a read clears them, a change in the same cycle still sets
    always_ff @(posedge clk) begin
        if (!rst_n)      flags <= '0;
        else if (rd_clr) flags <= set_now;
        else             flags <= flags | set_now;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> ((flags & $past(flags)) == $past(flags))); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (set_now == '0)) |=> (flags == '0)); // R4
    AST_RI_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[LN_RI]) |-> ($past(prev[LN_RI]) && !prev[LN_RI])); // R3
endmodule

// File: rtl/mdm_ctrl.sv
// Module: control register and the output pins it drives. Writes load bits
// 4:0 and ignore the upper bits. Assumes the caller decodes the address.
module mdm_ctrl
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              auto_rts_en,
    input  logic              rx_thresh_hit,
    output ctrl_t             ctrl,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              aux_out_n,
    output logic              irq_oe
);
    // Hold the control bits
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl <= '0;
        else if (wr_en) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Derive the pin levels; loopback parks both handshake outputs inactive
    always_comb begin
        dtr_n     = ~(ctrl.dtr & ~ctrl.loop);
        rts_n     = ~(ctrl.rts & ~ctrl.loop & ~(auto_rts_en & rx_thresh_hit));
        aux_out_n = ~ctrl.out_en;
        irq_oe    = ctrl.out_en;
    end

    AST_LOOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.loop) |-> (dtr_n && rts_n)); // R6
    AST_OP_VS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        aux_out_n != irq_oe); // R8
    AST_AUTO_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rx_thresh_hit) |-> rts_n); // R7
endmodule

// File: rtl/modem_ctl_status.sv
// Module: top of the modem handshake slice. Synchronizes the pins, selects
// pin or loopback levels, decodes the host strobes and forms the interrupt
// request. Assumes single-cycle strobes and read data taken in the same cycle.
module modem_ctl_status
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              cd_n,
    input  logic              msi_en,
    input  logic              auto_cts_en,
    input  logic              auto_rts_en,
    input  logic              rx_thresh_hit,
    output logic              dtr_n,
    output logic              rts_n,
    output logic              aux_out_n,
    output logic              irq_oe,
    output logic              msi_req
);
    ctrl_t                ctrl;
    logic [NUM_LINES-1:0] pin_raw_n;
    logic [NUM_LINES-1:0] pin_sync_n;
    logic [NUM_LINES-1:0] lb_lvl;
    logic [NUM_LINES-1:0] lvl;
    logic [NUM_LINES-1:0] flags;
    logic                 wr_ctrl;
    logic                 rd_stat;

    assign pin_raw_n = {cd_n, ri_n, dsr_n, cts_n};
    assign wr_ctrl   = bus_wr && (bus_addr == CTRL_ADDR);
    assign rd_stat   = bus_rd && (bus_addr == STAT_ADDR);

    mdm_sync #(.W(NUM_LINES), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw_n),
        .dout  (pin_sync_n)
    );

    mdm_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_ctrl),
        .wdata         (bus_wdata),
        .auto_rts_en   (auto_rts_en),
        .rx_thresh_hit (rx_thresh_hit),
        .ctrl          (ctrl),
        .dtr_n         (dtr_n),
        .rts_n         (rts_n),
        .aux_out_n     (aux_out_n),
        .irq_oe        (irq_oe)
    );

    // Pick the line levels: pins normally, control bits in loopback
    always_comb begin
        lb_lvl         = '0;
        lb_lvl[LN_CTS] = ctrl.rts;
        lb_lvl[LN_DSR] = ctrl.dtr;
        lb_lvl[LN_RI]  = ctrl.ri_lb;
        lb_lvl[LN_CD]  = ctrl.out_en;
        lvl            = ctrl.loop ? lb_lvl : ~pin_sync_n;
    end

    mdm_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_clr (rd_stat),
        .lvl    (lvl),
        .flags  (flags)
    );

    // Read mux for the two registers
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == CTRL_ADDR)      bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            else if (bus_addr == STAT_ADDR) bus_rdata = {lvl, flags};
        end
    end

    // Interrupt request; a CTS flag is masked while automatic CTS is on
    always_comb begin
        msi_req = msi_en & (flags[LN_DSR] | flags[LN_RI] | flags[LN_CD]
                          | (flags[LN_CTS] & ~auto_cts_en));
    end

    AST_MSI_CTS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && msi_req) |-> (flags[LN_DSR] | flags[LN_RI] | flags[LN_CD])); // R5
    AST_MSI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> msi_en); // R5
endmodule

// File: tb/tb_modem_ctl_status.sv
module tb_modem_ctl_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, cd_n = 1'b1;
    logic       msi_en = 1'b0, auto_cts_en = 1'b0, auto_rts_en = 1'b0, rx_thresh_hit = 1'b0;
    logic       dtr_n, rts_n, aux_out_n, irq_oe, msi_req;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    modem_ctl_status dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .cd_n(cd_n),
        .msi_en(msi_en), .auto_cts_en(auto_cts_en), .auto_rts_en(auto_rts_en),
        .rx_thresh_hit(rx_thresh_hit), .dtr_n(dtr_n), .rts_n(rts_n),
        .aux_out_n(aux_out_n), .irq_oe(irq_oe), .msi_req(msi_req)
    );

    // Reference model: pin history in a queue, levels and flags as integers
    logic [3:0] pin_q[$];
    logic [4:0] m_ctrl = '0;
    logic [3:0] m_last = '0;
    logic [3:0] m_flag = '0;
    bit         model_live = 0;

    function automatic logic [3:0] m_level();
        logic [3:0] older;
        if (m_ctrl[4]) return {m_ctrl[3], m_ctrl[2], m_ctrl[0], m_ctrl[1]};
        older = (pin_q.size() >= 2) ? pin_q[pin_q.size()-2] : 4'hF;
        return ~older;
    endfunction

    always @(posedge clk) begin
        logic [3:0] lv, rs;
        if (!rst_n) begin
            m_ctrl = '0; m_last = '0; m_flag = '0;
            pin_q.delete();
            pin_q.push_back(4'hF); pin_q.push_back(4'hF);
        end else begin
            lv = m_level();
            rs = lv ^ m_last;
            rs[2] = m_last[2] && !lv[2];
            if (bus_rd && bus_addr == 3'd6) m_flag = rs;
            else                            m_flag = m_flag | rs;
            m_last = lv;
            pin_q.push_back({cd_n, ri_n, dsr_n, cts_n});
            if (pin_q.size() > 4) void'(pin_q.pop_front());
            if (bus_wr && bus_addr == 3'd4) m_ctrl = bus_wdata[4:0];
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every clock, half a period after the edge
    always @(negedge clk) begin
        logic [7:0] er;
        if (model_live) begin
            chk("R6 dtr_n", {7'd0, dtr_n}, {7'd0, !(m_ctrl[0] && !m_ctrl[4])});
            chk("R7 rts_n", {7'd0, rts_n},
                {7'd0, !(m_ctrl[1] && !m_ctrl[4] && !(auto_rts_en && rx_thresh_hit))});
            chk("R8 aux_out_n/irq_oe", {6'd0, aux_out_n, irq_oe}, {6'd0, !m_ctrl[3], m_ctrl[3]});
            chk("R5 msi_req", {7'd0, msi_req},
                {7'd0, msi_en && (m_flag[1] || m_flag[2] || m_flag[3] || (m_flag[0] && !auto_cts_en))});
            er = 8'd0;
            if (bus_rd && bus_addr == 3'd4) er = {3'd0, m_ctrl};
            else if (bus_rd && bus_addr == 3'd6) er = {m_level(), m_flag};
            chk((bus_addr == 3'd6) ? "R1/R2/R3/R4/R9 status read" : "R10 read data", bus_rdata, er);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d; cyc(1);
        bus_wr = 0; bus_addr = 3'd0;
    endtask

    task automatic rd(input logic [2:0] a);
        bus_rd = 1; bus_addr = a; cyc(1);
        bus_rd = 0; bus_addr = 3'd0;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1; cyc(1);
        // R11: state right after reset
        chk("R11 reset outputs", {3'd0, dtr_n, rts_n, aux_out_n, irq_oe, msi_req}, 8'b0001_1100);
        model_live = 1;
        rd(3'd6); rd(3'd4);
        // R6 R7 R8 R10: control outputs and readback
        wr(3'd4, 8'hEB); rd(3'd4);
        wr(3'd5, 8'h00); rd(3'd4);          // R10 other address ignored
        rd(3'd2);
        auto_rts_en = 1; rx_thresh_hit = 1; cyc(2);
        rx_thresh_hit = 0; cyc(1); auto_rts_en = 0;
        // R1 R2 R5: CTS change, masked then unmasked
        msi_en = 1; auto_cts_en = 1;
        cts_n = 0; cyc(4); rd(3'd6);
        auto_cts_en = 0; cts_n = 1; cyc(4); rd(3'd6);
        // R3: ring falling edge of pin gives no flag, rising edge does
        ri_n = 0; cyc(4); rd(3'd6);
        ri_n = 1; cyc(4); rd(3'd6); rd(3'd6);
        // R2: carrier and data-set-ready
        cd_n = 0; dsr_n = 0; cyc(4); rd(3'd6);
        cd_n = 1; cyc(4); rd(3'd6);
        // R4: read lands before, on and after the flag-setting edge
        for (int off = 0; off < 5; off++) begin
            dsr_n = ~dsr_n; cyc(off); rd(3'd6); cyc(3); rd(3'd6);
        end
        // R9: loopback ignores pins, follows control bits
        wr(3'd4, 8'h10); cyc(2); rd(3'd6);
        cts_n = 0; ri_n = 0; cyc(4); rd(3'd6);
        for (int v = 0; v < 16; v++) begin
            wr(3'd4, {3'd0, 1'b1, v[3:0]});
            if (v % 2 == 0) rd(3'd6); else begin cyc(1); rd(3'd6); end
        end
        wr(3'd4, 8'h00); cyc(4); rd(3'd6); rd(3'd6);
        // R11: reset in mid-run
        wr(3'd4, 8'h0B); rst_n = 0; cyc(2); rst_n = 1; cyc(1); rd(3'd6);
        cyc(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule